// File: doc/BRIEF.md
# Binary Spike-Timing Learning Neuron

This block is the digital model of a small spiking layer: one or more output neurons, each fully connected to N input channels through synapses that hold a single bit each. Time advances in ticks (one tick stands for 1 ms). On every tick the block takes an N-bit vector of input spikes. Each neuron adds up the weights of the channels that spiked, subtracts a programmable leak, and compares the result with a programmable threshold. When the threshold is exceeded the neuron emits a one-cycle fire pulse and clears its potential.

Learning is unsupervised and follows the relative timing of input spikes and fires. Channels that spiked shortly before or on a fire tick are driven to the high state. Channels that spike shortly after a fire are driven to the low state. Spikes further apart than the window leave the weight alone. With two neurons, a fire of either one clears the potential of the other, which gives a winner-take-all contest. The weights can be read at any time and loaded through a synchronous port, so a test can start from any initial state.

Top module: `stdp_neuron_top`

## Requirements
- R1: After synchronous reset all weights, all potentials and all fire outputs are 0, and no spike seen before reset counts for learning.
- R2: With `init_we` high, `wt_o` equals `init_wt` after the next clock edge, taking priority over learning; bit k*N+i is the weight from channel i to neuron k.
- R3: On a tick with no fire and no inhibition, a neuron's potential becomes pot + popcount(pre_spk & weights) - leak; without a tick the potential and weights are held.
- R4: A neuron fires on a tick when pot + popcount(pre_spk & weights) is strictly greater than `thresh`; its potential is then 0.
- R5: On a fire tick, each channel whose last spike lies 0 to WIN-1 ticks back (0 = the fire tick itself) gets weight 1 for that neuron.
- R6: On a non-fire tick that lies 1 to WIN-1 ticks after that neuron's last fire, each channel spiking on that tick gets weight 0.
- R7: A spike WIN or more ticks before a fire, or WIN or more ticks after it, leaves the weight unchanged.
- R8: A potentiation of a weight that is already 1, or a depression of a weight that is already 0, leaves it unchanged.
- R9: A fire of any neuron clears the potential of every other neuron on the same tick.
- R10: When the leak exceeds the integrated value, the potential becomes 0 and does not wrap.
- R11: `fire_o` is high only in the cycle after a tick that fired; without a tick, spike inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-step strobe, one cycle per tick |
| pre_spk | input | N | Input spike vector for this tick |
| thresh | input | POT_W | Fire threshold |
| leak | input | POT_W | Amount subtracted per tick |
| init_we | input | 1 | Load weights from `init_wt` |
| init_wt | input | NEU*N | Weights to load |
| wt_o | output | NEU*N | Current weights |
| pot_o | output | NEU*POT_W | Current potentials |
| fire_o | output | NEU | Fire pulses |

## Verification
The bench targets the window edges: a spike exactly WIN ticks before a fire and one WIN-1 ticks before, and the same pair after a fire; an off-by-one window would flip one of the two weights. It drives a leak larger than the integrated value, where a wrapping subtractor would leave a huge potential, and an input equal to the threshold, where a non-strict compare would fire. It makes one neuron fire while the other sits below threshold, where a missing inhibition path would leave the loser's potential standing, and checks that the loser's weights do not learn from the winner's fire.

// File: rtl/stdp_pkg.sv
package stdp_pkg;

    typedef enum logic [1:0] {
        SYN_HOLD = 2'd0,
        SYN_POT  = 2'd1,
        SYN_DEP  = 2'd2
    } syn_act_e;

    // Next value of a single binary synapse for a requested action.
    function automatic logic syn_next(input syn_act_e act, input logic cur);
        case (act)
            SYN_POT: syn_next = 1'b1;
            SYN_DEP: syn_next = 1'b0;
            default: syn_next = cur;
        endcase
    endfunction

endpackage

// File: rtl/stdp_pre_age.sv
module stdp_pre_age #(
    parameter int N     = 16,
    parameter int WIN   = 10,
    parameter int AGE_W = $clog2(WIN + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [N-1:0] pre_spk,
    output logic [N-1:0] pre_recent
);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WIN);
    localparam logic [AGE_W-1:0] AGE_LIM = AGE_W'(WIN - 1);

    for (genvar i = 0; i < N; i++) begin : g_ch
        logic [AGE_W-1:0] age_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                age_q <= AGE_MAX;
            end else if (tick) begin
                if (pre_spk[i])
                    age_q <= '0;
                else if (age_q < AGE_MAX)
                    age_q <= age_q + 1'b1;
            end
        end

        // Spike this tick, or the previous one lies fewer than WIN ticks back.
        assign pre_recent[i] = pre_spk[i] | (age_q < AGE_LIM);

        p_age_bound_r7: assert property (@(posedge clk) disable iff (rst)
            age_q <= AGE_MAX);
    end

endmodule

// File: rtl/stdp_soma.sv
module stdp_soma #(
    parameter int N     = 16,
    parameter int POT_W = 8,
    parameter int WIN   = 10,
    parameter int CNT_W = $clog2(WIN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [N-1:0]     pre_spk,
    input  logic [N-1:0]     wt,
    input  logic [POT_W-1:0] thresh,
    input  logic [POT_W-1:0] leak,
    input  logic             inhibit_in,
    output logic             fire_now,
    output logic             fire_q,
    output logic [POT_W-1:0] pot_q,
    output logic             post_recent
);
    localparam int SUM_W = $clog2(N + 1);
    localparam logic [CNT_W-1:0] SINCE_MAX = CNT_W'(WIN);
    localparam logic [CNT_W-1:0] SINCE_LIM = CNT_W'(WIN - 1);

    logic [SUM_W-1:0] sum;
    logic [POT_W:0]   integ_wide;
    logic [POT_W-1:0] integ;
    logic [POT_W-1:0] leaked;
    logic [CNT_W-1:0] since_q;

    always_comb begin
        sum = '0;
        for (int i = 0; i < N; i++)
            sum = sum + SUM_W'(pre_spk[i] & wt[i]);
    end

    assign integ_wide = {1'b0, pot_q} + (POT_W + 1)'(sum);
    assign integ      = integ_wide[POT_W] ? '1 : integ_wide[POT_W-1:0];
    assign leaked     = (integ > leak) ? (integ - leak) : '0;
    assign fire_now   = tick & (integ > thresh);

    // A spike on the current tick lies since_q+1 ticks after the last fire.
    assign post_recent = since_q < SINCE_LIM;

    always_ff @(posedge clk) begin
        if (rst) begin
            pot_q   <= '0;
            fire_q  <= 1'b0;
            since_q <= SINCE_MAX;
        end else begin
            fire_q <= fire_now;
            if (tick) begin
                if (fire_now || inhibit_in)
                    pot_q <= '0;
                else
                    pot_q <= leaked;
                if (fire_now)
                    since_q <= '0;
                else if (since_q < SINCE_MAX)
                    since_q <= since_q + 1'b1;
            end
        end
    end

    p_no_tick_r11: assert property (@(posedge clk) disable iff (rst)
        !tick |=> !fire_q);
    p_fire_clears_r4: assert property (@(posedge clk) disable iff (rst)
        fire_q |-> pot_q == '0);
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(pot_q));
    p_inhibit_r9: assert property (@(posedge clk) disable iff (rst)
        (tick && inhibit_in) |=> pot_q == '0);

endmodule

// File: rtl/stdp_syn_bank.sv
module stdp_syn_bank
    import stdp_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         fire_now,
    input  logic [N-1:0] pre_spk,
    input  logic [N-1:0] pre_recent,
    input  logic         post_recent,
    input  logic         init_we,
    input  logic [N-1:0] init_wt,
    output logic [N-1:0] wt_q
);
    syn_act_e act [N];

    for (genvar i = 0; i < N; i++) begin : g_syn
        always_comb begin
            if (fire_now && pre_recent[i])
                act[i] = SYN_POT;
            else if (tick && !fire_now && post_recent && pre_spk[i])
                act[i] = SYN_DEP;
            else
                act[i] = SYN_HOLD;
        end

        always_ff @(posedge clk) begin
            if (rst)
                wt_q[i] <= 1'b0;
            else if (init_we)
                wt_q[i] <= init_wt[i];
            else
                wt_q[i] <= syn_next(act[i], wt_q[i]);
        end
    end

    p_init_r2: assert property (@(posedge clk) disable iff (rst)
        init_we |=> wt_q == $past(init_wt));
    p_potentiate_r5: assert property (@(posedge clk) disable iff (rst)
        (!init_we && fire_now) |=> (wt_q & $past(pre_spk)) == $past(pre_spk));
    p_depress_r6: assert property (@(posedge clk) disable iff (rst)
        (!init_we && tick && !fire_now && post_recent) |=> (wt_q & $past(pre_spk)) == '0);
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!init_we && !fire_now && !(tick && post_recent)) |=> $stable(wt_q));

endmodule

// File: rtl/stdp_neuron_top.sv
module stdp_neuron_top #(
    parameter int N     = 16,
    parameter int NEU   = 2,
    parameter int POT_W = 8,
    parameter int WIN   = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic [N-1:0]         pre_spk,
    input  logic [POT_W-1:0]     thresh,
    input  logic [POT_W-1:0]     leak,
    input  logic                 init_we,
    input  logic [NEU*N-1:0]     init_wt,
    output logic [NEU*N-1:0]     wt_o,
    output logic [NEU*POT_W-1:0] pot_o,
    output logic [NEU-1:0]       fire_o
);
    localparam int CNT_W = $clog2(WIN + 1);

    logic [N-1:0]   pre_recent;
    logic [NEU-1:0] fire_now_v;
    logic [NEU-1:0] inhib_v;
    logic [NEU-1:0] post_recent_v;

    stdp_pre_age #(.N(N), .WIN(WIN), .AGE_W(CNT_W)) i_age (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .pre_spk    (pre_spk),
        .pre_recent (pre_recent)
    );

    for (genvar k = 0; k < NEU; k++) begin : g_neu
        assign inhib_v[k] = |(fire_now_v & ~(NEU'(1) << k));

        stdp_soma #(.N(N), .POT_W(POT_W), .WIN(WIN), .CNT_W(CNT_W)) i_soma (
            .clk         (clk),
            .rst         (rst),
            .tick        (tick),
            .pre_spk     (pre_spk),
            .wt          (wt_o[k*N +: N]),
            .thresh      (thresh),
            .leak        (leak),
            .inhibit_in  (inhib_v[k]),
            .fire_now    (fire_now_v[k]),
            .fire_q      (fire_o[k]),
            .pot_q       (pot_o[k*POT_W +: POT_W]),
            .post_recent (post_recent_v[k])
        );

        stdp_syn_bank #(.N(N)) i_bank (
            .clk         (clk),
            .rst         (rst),
            .tick        (tick),
            .fire_now    (fire_now_v[k]),
            .pre_spk     (pre_spk),
            .pre_recent  (pre_recent),
            .post_recent (post_recent_v[k]),
            .init_we     (init_we),
            .init_wt     (init_wt[k*N +: N]),
            .wt_q        (wt_o[k*N +: N])
        );
    end

endmodule

// File: tb/test_stdp_neuron_top.sv
`timescale 1ns/1ps
module test_stdp_neuron_top;
    localparam int N = 16, NEU = 2, POT_W = 8, WIN = 10;

    logic clk = 1'b0;
    logic rst, tick, init_we;
    logic [N-1:0] pre_spk;
    logic [POT_W-1:0] thresh, leak;
    logic [NEU*N-1:0] init_wt, wt_o;
    logic [NEU*POT_W-1:0] pot_o;
    logic [NEU-1:0] fire_o;

    int n_chk = 0, n_bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    stdp_neuron_top #(.N(N), .NEU(NEU), .POT_W(POT_W), .WIN(WIN)) i_stdp_neuron_top (
        .clk(clk), .rst(rst), .tick(tick), .pre_spk(pre_spk), .thresh(thresh),
        .leak(leak), .init_we(init_we), .init_wt(init_wt), .wt_o(wt_o),
        .pot_o(pot_o), .fire_o(fire_o)
    );

    typedef struct packed {
        logic [N-1:0]     pre;
        logic [POT_W-1:0] lk;
        logic [POT_W-1:0] exp_pot;
    } vec_t;

    // Neuron 0 weights 0x00FF, threshold 200: integration and leak, no fire.
    localparam vec_t VECS [7] = '{
        '{16'hFFFF, 8'd0,  8'd8},
        '{16'h000F, 8'd1,  8'd11},
        '{16'hFF00, 8'd0,  8'd11},
        '{16'h0001, 8'd3,  8'd9},
        '{16'h0000, 8'd20, 8'd0},
        '{16'h00FF, 8'd2,  8'd6},
        '{16'h00AA, 8'd0,  8'd10}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_tick(input logic [N-1:0] p);
        @(negedge clk);
        tick = 1'b1;
        pre_spk = p;
        @(negedge clk);
        tick = 1'b0;
        pre_spk = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic load(input logic [NEU*N-1:0] w);
        @(negedge clk);
        init_we = 1'b1;
        init_wt = w;
        @(negedge clk);
        init_we = 1'b0;
    endtask

    initial begin
        while (cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; tick = 1'b0; init_we = 1'b0; pre_spk = '0;
        init_wt = '0; thresh = 8'd200; leak = '0;
        do_reset();

        // R1: reset state
        check("R1 weights", wt_o, 32'h0);
        check("R1 potentials", pot_o, 32'h0);
        check("R1 fire", fire_o, 32'h0);

        // R2: load, bit k*N+i is neuron k channel i
        load({16'h0000, 16'h00FF});
        check("R2 init load", wt_o, 32'h0000_00FF);

        // R3 R10: vector table
        for (int v = 0; v < 7; v++) begin
            leak = VECS[v].lk;
            do_tick(VECS[v].pre);
            check($sformatf("R3/R10 vector %0d pot0", v), pot_o[POT_W-1:0], VECS[v].exp_pot);
            check($sformatf("R4 vector %0d no fire", v), fire_o, 32'h0);
        end
        check("R3 neuron1 pot with zero weights", pot_o[2*POT_W-1:POT_W], 32'h0);

        // R11: spikes without tick have no effect
        @(negedge clk);
        pre_spk = 16'hFFFF;
        @(negedge clk);
        @(negedge clk);
        pre_spk = '0;
        check("R11 no tick holds pot", pot_o[POT_W-1:0], 32'd10);
        check("R11 no tick no fire", fire_o, 32'h0);
        check("R11 no tick weights held", wt_o, 32'h0000_00FF);

        // R4 R5 R7 R8: fire and potentiation window
        do_reset();
        load({16'h0000, 16'h0003});
        thresh = 8'd1; leak = 8'd0;
        do_tick(16'h0004);            // t0: ch2, delay WIN at fire
        do_tick(16'h0008);            // t1: ch3, delay WIN-1 at fire
        for (int t = 2; t < 10; t++) do_tick(16'h0000);
        check("R4 equal to threshold no fire", fire_o, 32'h0);
        do_tick(16'h0003);            // t10: sum 2 > 1
        check("R4 fire neuron0", fire_o, 32'h1);
        check("R4 pot cleared on fire", pot_o[POT_W-1:0], 32'h0);
        check("R5/R7/R8 neuron0 weights after fire", wt_o[N-1:0], 32'h000B);
        check("R5 neuron1 not learning", wt_o[2*N-1:N], 32'h0);
        do_tick(16'h0000);            // t11
        check("R11 fire pulse ends", fire_o, 32'h0);

        // R6 R7 R8: depression window
        leak = 8'd1;
        do_tick(16'h0021);            // t12: ch0 high, ch5 low, delay 2
        check("R6/R8 depress after fire", wt_o[N-1:0], 32'h000A);
        for (int t = 13; t < 19; t++) do_tick(16'h0000);
        do_tick(16'h0002);            // t19: ch1, delay WIN-1
        check("R6 depress at delay WIN-1", wt_o[N-1:0], 32'h0008);
        do_tick(16'h0008);            // t20: ch3, delay WIN
        check("R7 no depress at delay WIN", wt_o[N-1:0], 32'h0008);
        check("R4 no fire during depression", fire_o, 32'h0);

        // R9: winner-take-all
        do_reset();
        load({16'h00FF, 16'hFFFF});
        thresh = 8'd10; leak = 8'd0;
        do_tick(16'h00FF);
        check("R3 both integrate", pot_o, {8'd8, 8'd8});
        do_tick(16'hFF00);
        check("R9 only neuron0 fires", fire_o, 32'h1);
        check("R9 loser pot cleared", pot_o[2*POT_W-1:POT_W], 32'h0);
        check("R9 winner pot cleared", pot_o[POT_W-1:0], 32'h0);
        check("R9 loser weights unchanged", wt_o, 32'h00FF_FFFF);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule